// File: doc/BRIEF.md
# System Control Register Bank

This block is a 4 KB window of control and identification registers for a chip's housekeeping plane. It sits on a plain 32-bit register bus: a request strobe with a write flag, a word address and write data. Eight general configuration slots share the lowest 32 bytes. A loop-lock status word, an auxiliary identifier and a main identifier sit at fixed offsets higher up. A four-word window for a configuration-channel transaction block is decoded here and handed on through a strobe. The registers behind that window live in another block.

The build-time main identifier selects the variant. Its part-number field, bits [11:4], picks which configuration slots exist. It also decides whether slot 0 and slot 1 drive the remap line and the LED bus. Three part numbers name variants A, B and C: 0xA1, 0xB2 and 0xC3. Any other value is the generic variant. A slot that is absent in the chosen variant behaves exactly like a hole in the map. Read data comes back one cycle after the request. A one-cycle error flag marks accesses that hit nothing, hit a misaligned address, or write a read-only register.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, slot 0 holds the CFG0_INIT parameter, slots 1, 2, 5, 6 and 7 hold zero, and the lock word (offset 0x100) reads 0xFFFF0001 while all eight lock inputs are high.
- R2: A read request is answered in the next cycle with `rd_valid` high and the data. A write request never raises `rd_valid`. A write takes effect at the edge that accepts it, so the next read returns the new value.
- R3: Slots sit at offset 4*n (n = 0..7). Slots 0, 1 and 4 exist in every variant. Slots 2 and 5 exist only in variants A, B and C. Slot 6 exists only in A and C. Slot 7 exists only in C. Slot 3 exists only in the generic variant. Present writable slots (0, 1, 2, 5, 6, 7) hold all 32 written bits.
- R4: A read of an absent slot, an unmapped offset or an address whose two low bits are not zero returns zero. A write to any of these changes nothing. Either access raises `bad_access` for exactly the cycle in which the read answer would appear.
- R5: Slot 3 returns `switch_in`, or zero when SWITCH_PRESENT is 0. Slot 4 returns CFG4_VALUE, offset 0xFF8 returns AUXID_VALUE and offset 0xFFC returns ID_VALUE. Writes to these four are ignored and raise `bad_access`.
- R6: Outside variant C, `remap_o` equals bit 0 of slot 0 at all times. In variant C it stays 0.
- R7: Outside variant C, `led_o[i]` equals bit i of slot 1. In variant C the LED bus stays 0.
- R8: Only bits [31:24] of the lock word are writable; they form a mask. Bits [23:16] read the live `lock_in`. Bits [15:1] read zero. Bit 0 reads 1 exactly when every lock input whose mask bit is set is high.
- R9: In variant C, a write to slot 7 is returned by the next read of slot 7.
- R10: Offsets 0xA0, 0xA4, 0xA8 and 0xAC never raise `bad_access`. They read zero here. For reads and writes alike, `xchan_hit` pulses in the cycle that answers the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (12) | Byte address inside the window |
| req_wdata | input | DW (32) | Write data |
| switch_in | input | DW (32) | External switch levels read through slot 3 |
| lock_in | input | LOOPS (8) | Per-loop lock indications |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | DW (32) | Read answer |
| bad_access | output | 1 | One-cycle flag for an access that hit nothing or wrote a read-only register |
| xchan_hit | output | 1 | One-cycle strobe for an access to the channel window |
| remap_o | output | 1 | Remap control level |
| led_o | output | LED_W (8) | LED control levels |

## Verification
The bench builds five copies of the block side by side: variants A, B and C, plus the generic variant twice, once with the switch input wired and once tied off. Every access goes to all five at once, so one pass over all 1024 word offsets compares each variant's presence map, read data and error flag against a per-variant shadow model. Write sweeps over the whole window push patterns into every offset, including the read-only and absent ones. A grid of mask and lock-input values exercises the summary bit.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW_DEF    = 32;
    localparam int AW_DEF    = 12;
    localparam int LED_W_DEF = 8;
    localparam int LOOPS_DEF = 8;

    // part numbers that name the variants
    localparam logic [7:0] PART_A = 8'hA1;
    localparam logic [7:0] PART_B = 8'hB2;
    localparam logic [7:0] PART_C = 8'hC3;

    // fixed offsets
    localparam logic [11:0] OFF_CHAN_LO = 12'h0A0;
    localparam logic [11:0] OFF_CHAN_HI = 12'h0AC;
    localparam logic [11:0] OFF_LOCK    = 12'h100;
    localparam logic [11:0] OFF_AUXID   = 12'hFF8;
    localparam logic [11:0] OFF_MAINID  = 12'hFFC;
    localparam logic [11:0] SLOT_SPAN   = 12'h020;

    typedef enum logic [3:0] {
        SEL_NONE   = 4'd0,
        SEL_CFG0   = 4'd1,
        SEL_CFG1   = 4'd2,
        SEL_CFG2   = 4'd3,
        SEL_CFG3   = 4'd4,
        SEL_CFG4   = 4'd5,
        SEL_CFG5   = 4'd6,
        SEL_CFG6   = 4'd7,
        SEL_CFG7   = 4'd8,
        SEL_LOCK   = 4'd9,
        SEL_AUXID  = 4'd10,
        SEL_MAINID = 4'd11,
        SEL_CHAN   = 4'd12
    } sel_e;

    // which configuration slots exist for a given part number
    function automatic logic [7:0] slot_map(input logic [7:0] part);
        logic       fam;
        logic [7:0] m;
        fam = (part == PART_A) || (part == PART_B) || (part == PART_C);
        m   = 8'b0001_0011;
        if (fam) begin
            m[2] = 1'b1;
            m[5] = 1'b1;
        end else begin
            m[3] = 1'b1;
        end
        if (part == PART_A || part == PART_C) m[6] = 1'b1;
        if (part == PART_C)                   m[7] = 1'b1;
        return m;
    endfunction

    function automatic logic drives_io(input logic [7:0] part);
        return part != PART_C;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int         AW   = AW_DEF,
    parameter logic [7:0] PART = 8'h00
) (
    input  logic [AW-1:0] addr,
    input  logic          write,
    output sel_e          sel,
    output logic          bad
);
    localparam logic [7:0] PRESENT = slot_map(PART);

    logic [2:0] slot;
    logic       ro;

    assign slot = addr[4:2];

    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr < AW'(SLOT_SPAN)) begin
                if (PRESENT[slot]) sel = sel_e'(4'(SEL_CFG0) + {1'b0, slot});
            end else if (addr >= AW'(OFF_CHAN_LO) && addr <= AW'(OFF_CHAN_HI)) begin
                sel = SEL_CHAN;
            end else if (addr == AW'(OFF_LOCK)) begin
                sel = SEL_LOCK;
            end else if (addr == AW'(OFF_AUXID)) begin
                sel = SEL_AUXID;
            end else if (addr == AW'(OFF_MAINID)) begin
                sel = SEL_MAINID;
            end
        end
        ro  = (sel == SEL_CFG3) || (sel == SEL_CFG4) ||
              (sel == SEL_AUXID) || (sel == SEL_MAINID);
        bad = (sel == SEL_NONE) || (write && ro);
    end

    always_comb begin
        AST_MISALIGNED_UNMAPPED: assert (addr[1:0] == 2'b00 || bad) else $error("misaligned decoded"); // R4
    end

endmodule

// File: rtl/sysctl_cfgfile.sv
module sysctl_cfgfile
    import sysctl_pkg::*;
#(
    parameter int            DW        = DW_DEF,
    parameter int            LED_W     = LED_W_DEF,
    parameter logic [DW-1:0] CFG0_INIT = '0,
    parameter bit            DRIVES_IO = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  sel_e                sel,
    input  logic [DW-1:0]       wdata,
    output logic [7:0][DW-1:0]  slot_val,
    output logic                remap_o,
    output logic [LED_W-1:0]    led_o
);
    typedef struct packed {
        logic [DW-1:0] c0;
        logic [DW-1:0] c1;
        logic [DW-1:0] c2;
        logic [DW-1:0] c5;
        logic [DW-1:0] c6;
        logic [DW-1:0] c7;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_CFG0: st_d.c0 = wdata;
                SEL_CFG1: st_d.c1 = wdata;
                SEL_CFG2: st_d.c2 = wdata;
                SEL_CFG5: st_d.c5 = wdata;
                SEL_CFG6: st_d.c6 = wdata;
                SEL_CFG7: st_d.c7 = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.c0 <= CFG0_INIT;
        end else begin
            st_q    <= st_d;
        end
    end

    always_comb begin
        slot_val    = '0;
        slot_val[0] = st_q.c0;
        slot_val[1] = st_q.c1;
        slot_val[2] = st_q.c2;
        slot_val[5] = st_q.c5;
        slot_val[6] = st_q.c6;
        slot_val[7] = st_q.c7;
    end

    generate
        if (DRIVES_IO) begin : g_io
            assign remap_o = st_q.c0[0];
            assign led_o   = st_q.c1[LED_W-1:0];
        end else begin : g_noio
            assign remap_o = 1'b0;
            assign led_o   = '0;
        end
    endgenerate

    AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(remap_o)) else $error("remap moved without write"); // R6
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(led_o)) else $error("leds moved without write"); // R7

endmodule

// File: rtl/sysctl_lockstat.sv
module sysctl_lockstat
    import sysctl_pkg::*;
#(
    parameter int DW    = DW_DEF,
    parameter int LOOPS = LOOPS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LOOPS-1:0] wmask,
    input  logic [LOOPS-1:0] lock_in,
    output logic [DW-1:0]    word
);
    localparam int MASK_LSB = DW - LOOPS;
    localparam int LOCK_LSB = 16;

    logic [LOOPS-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_en) mask_d = wmask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    always_comb begin
        word                        = '0;
        word[MASK_LSB +: LOOPS]     = mask_q;
        word[LOCK_LSB +: LOOPS]     = lock_in;
        word[0]                     = &(lock_in | ~mask_q);
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q)) else $error("mask changed without write"); // R8

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int            DW             = DW_DEF,
    parameter int            AW             = AW_DEF,
    parameter int            LED_W          = LED_W_DEF,
    parameter int            LOOPS          = LOOPS_DEF,
    parameter logic [DW-1:0] ID_VALUE       = 32'h0000_0A10,
    parameter logic [DW-1:0] AUXID_VALUE    = '0,
    parameter logic [DW-1:0] CFG4_VALUE     = '0,
    parameter logic [DW-1:0] CFG0_INIT      = '0,
    parameter bit            SWITCH_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW-1:0]    switch_in,
    input  logic [LOOPS-1:0] lock_in,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             bad_access,
    output logic             xchan_hit,
    output logic             remap_o,
    output logic [LED_W-1:0] led_o
);
    localparam logic [7:0] PART   = ID_VALUE[11:4];
    localparam bit         IO_ON  = drives_io(PART);

    typedef struct packed {
        logic          rd_valid;
        logic [DW-1:0] rd_data;
        logic          bad;
        logic          chan;
    } resp_t;

    resp_t             rs_d, rs_q;
    sel_e              sel;
    logic              dec_bad;
    logic              wr_ok;
    logic [7:0][DW-1:0] slot_val;
    logic [DW-1:0]     lock_word;
    logic [DW-1:0]     rdat;

    sysctl_decode #(.AW(AW), .PART(PART)) u_dec (
        .addr  (req_addr),
        .write (req_write),
        .sel   (sel),
        .bad   (dec_bad)
    );

    assign wr_ok = req_valid && req_write && !dec_bad;

    sysctl_cfgfile #(
        .DW(DW), .LED_W(LED_W), .CFG0_INIT(CFG0_INIT), .DRIVES_IO(IO_ON)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .sel      (sel),
        .wdata    (req_wdata),
        .slot_val (slot_val),
        .remap_o  (remap_o),
        .led_o    (led_o)
    );

    sysctl_lockstat #(.DW(DW), .LOOPS(LOOPS)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok && sel == SEL_LOCK),
        .wmask   (req_wdata[DW-1 -: LOOPS]),
        .lock_in (lock_in),
        .word    (lock_word)
    );

    // read multiplexer
    always_comb begin
        rdat = '0;
        case (sel)
            SEL_CFG0, SEL_CFG1, SEL_CFG2, SEL_CFG5, SEL_CFG6, SEL_CFG7:
                rdat = slot_val[req_addr[4:2]];
            SEL_CFG3:   rdat = SWITCH_PRESENT ? switch_in : '0;
            SEL_CFG4:   rdat = CFG4_VALUE;
            SEL_LOCK:   rdat = lock_word;
            SEL_AUXID:  rdat = AUXID_VALUE;
            SEL_MAINID: rdat = ID_VALUE;
            default:    rdat = '0;
        endcase
    end

    always_comb begin
        rs_d = '0;
        if (req_valid) begin
            rs_d.rd_valid = !req_write;
            rs_d.rd_data  = (!req_write && !dec_bad) ? rdat : '0;
            rs_d.bad      = dec_bad;
            rs_d.chan     = (sel == SEL_CHAN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_valid   = rs_q.rd_valid;
    assign rd_data    = rs_q.rd_data;
    assign bad_access = rs_q.bad;
    assign xchan_hit  = rs_q.chan;

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rd_valid) else $error("read not answered"); // R2
    AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write)) else $error("answer without read"); // R2
    AST_BAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && bad_access |-> rd_data == '0) else $error("bad read returned data"); // R4
    AST_BAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(req_valid)) else $error("bad flag without request"); // R4
    AST_CHAN_NOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        xchan_hit |-> !bad_access) else $error("channel window flagged"); // R10

endmodule

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;
    localparam int NV = 5;
    localparam logic [31:0] IDV   [NV] = '{32'h4100_0A13, 32'h4100_0B23, 32'h4100_0C33,
                                          32'h4100_05D3, 32'h4100_05D3};
    localparam logic [31:0] AIDV  [NV] = '{32'h0300_0011, 32'h0300_0022, 32'h0300_0033,
                                          32'h0300_0044, 32'h0300_0055};
    localparam logic [31:0] C4V   [NV] = '{32'h1234_0001, 32'h1234_0002, 32'h1234_0003,
                                          32'h1234_0004, 32'h1234_0005};
    localparam logic [31:0] C0I   [NV] = '{32'h0000_0001, 32'h0000_0000, 32'h0000_0001,
                                          32'h8000_0003, 32'h0000_0002};
    localparam bit          SWP   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n, rq_v, rq_w;
    logic [11:0] rq_a;
    logic [31:0] rq_d, sw;
    logic [7:0]  lk;
    logic        rdv [NV];
    logic        bd  [NV];
    logic        ch  [NV];
    logic        rm  [NV];
    logic [31:0] rdd [NV];
    logic [7:0]  ld  [NV];

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [31:0] sh  [NV][8];
    logic [7:0]  msk [NV];

    always #2.5 clk = ~clk;

    sysctl_regbank #(.ID_VALUE(IDV[0]), .AUXID_VALUE(AIDV[0]), .CFG4_VALUE(C4V[0]),
                     .CFG0_INIT(C0I[0]), .SWITCH_PRESENT(SWP[0])) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_v), .req_write(rq_w), .req_addr(rq_a),
        .req_wdata(rq_d), .switch_in(sw), .lock_in(lk), .rd_valid(rdv[0]), .rd_data(rdd[0]),
        .bad_access(bd[0]), .xchan_hit(ch[0]), .remap_o(rm[0]), .led_o(ld[0]));
    sysctl_regbank #(.ID_VALUE(IDV[1]), .AUXID_VALUE(AIDV[1]), .CFG4_VALUE(C4V[1]),
                     .CFG0_INIT(C0I[1]), .SWITCH_PRESENT(SWP[1])) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_v), .req_write(rq_w), .req_addr(rq_a),
        .req_wdata(rq_d), .switch_in(sw), .lock_in(lk), .rd_valid(rdv[1]), .rd_data(rdd[1]),
        .bad_access(bd[1]), .xchan_hit(ch[1]), .remap_o(rm[1]), .led_o(ld[1]));
    sysctl_regbank #(.ID_VALUE(IDV[2]), .AUXID_VALUE(AIDV[2]), .CFG4_VALUE(C4V[2]),
                     .CFG0_INIT(C0I[2]), .SWITCH_PRESENT(SWP[2])) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_v), .req_write(rq_w), .req_addr(rq_a),
        .req_wdata(rq_d), .switch_in(sw), .lock_in(lk), .rd_valid(rdv[2]), .rd_data(rdd[2]),
        .bad_access(bd[2]), .xchan_hit(ch[2]), .remap_o(rm[2]), .led_o(ld[2]));
    sysctl_regbank #(.ID_VALUE(IDV[3]), .AUXID_VALUE(AIDV[3]), .CFG4_VALUE(C4V[3]),
                     .CFG0_INIT(C0I[3]), .SWITCH_PRESENT(SWP[3])) u3 (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_v), .req_write(rq_w), .req_addr(rq_a),
        .req_wdata(rq_d), .switch_in(sw), .lock_in(lk), .rd_valid(rdv[3]), .rd_data(rdd[3]),
        .bad_access(bd[3]), .xchan_hit(ch[3]), .remap_o(rm[3]), .led_o(ld[3]));
    sysctl_regbank #(.ID_VALUE(IDV[4]), .AUXID_VALUE(AIDV[4]), .CFG4_VALUE(C4V[4]),
                     .CFG0_INIT(C0I[4]), .SWITCH_PRESENT(SWP[4])) u4 (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_v), .req_write(rq_w), .req_addr(rq_a),
        .req_wdata(rq_d), .switch_in(sw), .lock_in(lk), .rd_valid(rdv[4]), .rd_data(rdd[4]),
        .bad_access(bd[4]), .xchan_hit(ch[4]), .remap_o(rm[4]), .led_o(ld[4]));

    // ---------------- model (v: 0=A, 1=B, 2=C, 3/4=generic) ----------------
    function automatic bit has(int v, int i);
        case (i)
            0, 1, 4: return 1'b1;
            2, 5:    return v <= 2;
            3:       return v >= 3;
            6:       return v == 0 || v == 2;
            default: return v == 2;
        endcase
    endfunction

    function automatic bit is_chan(logic [11:0] a);
        return a[1:0] == 2'b00 && a >= 12'h0A0 && a <= 12'h0AC;
    endfunction

    function automatic bit m_bad(int v, logic [11:0] a, bit w);
        if (a[1:0] != 2'b00) return 1'b1;
        if (a < 12'h020) begin
            if (!has(v, int'(a[4:2]))) return 1'b1;
            return w && (a[4:2] == 3'd3 || a[4:2] == 3'd4);
        end
        if (is_chan(a) || a == 12'h100) return 1'b0;
        if (a == 12'hFF8 || a == 12'hFFC) return w;
        return 1'b1;
    endfunction

    function automatic logic [31:0] m_rd(int v, logic [11:0] a);
        if (m_bad(v, a, 1'b0)) return 32'h0;
        if (a < 12'h020) begin
            if (a[4:2] == 3'd3) return SWP[v] ? sw : 32'h0;
            if (a[4:2] == 3'd4) return C4V[v];
            return sh[v][a[4:2]];
        end
        if (a == 12'h100) return {msk[v], lk, 15'h0, &(lk | ~msk[v])};
        if (a == 12'hFF8) return AIDV[v];
        if (a == 12'hFFC) return IDV[v];
        return 32'h0;
    endfunction

    function automatic string tag_of(int v, logic [11:0] a);
        if (m_bad(v, a, 1'b0)) return "R4";
        if (is_chan(a)) return "R10";
        if (a == 12'h100) return "R8";
        if (a == 12'h01C) return "R9";
        if (a == 12'h00C || a == 12'h010 || a >= 12'hFF8) return "R5";
        return "R3";
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 8; i++) sh[v][i] = 32'h0;
            sh[v][0] = C0I[v];
            msk[v]   = 8'hFF;
        end
    endtask

    task automatic check_io();
        for (int v = 0; v < NV; v++) begin
            chk("R6", $sformatf("remap v%0d", v), {31'h0, rm[v]}, {31'h0, v != 2 ? sh[v][0][0] : 1'b0});
            chk("R7", $sformatf("leds v%0d", v), {24'h0, ld[v]}, {24'h0, v != 2 ? sh[v][1][7:0] : 8'h0});
        end
    endtask

    task automatic access(bit w, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        rq_v = 1'b1; rq_w = w; rq_a = a; rq_d = d;
        @(negedge clk);
        rq_v = 1'b0;
        for (int v = 0; v < NV; v++) begin
            chk("R2", $sformatf("rd_valid v%0d a=%h", v, a), {31'h0, rdv[v]}, {31'h0, !w});
            chk(m_bad(v, a, w) && !m_bad(v, a, 1'b0) ? "R5" : (is_chan(a) ? "R10" : "R4"),
                $sformatf("bad_access v%0d a=%h w=%0d", v, a, w),
                {31'h0, bd[v]}, {31'h0, m_bad(v, a, w)});
            chk("R10", $sformatf("xchan_hit v%0d a=%h", v, a), {31'h0, ch[v]}, {31'h0, is_chan(a)});
            if (!w) chk(tag_of(v, a), $sformatf("rd_data v%0d a=%h", v, a), rdd[v], m_rd(v, a));
        end
        if (w) begin
            for (int v = 0; v < NV; v++) begin
                if (!m_bad(v, a, 1'b1)) begin
                    if (a < 12'h020) sh[v][a[4:2]] = d;
                    else if (a == 12'h100) msk[v] = d[31:24];
                end
            end
        end
        check_io();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rq_v = 1'b0; rq_w = 1'b0; rq_a = '0; rq_d = '0;
        sw = 32'h5A5A_C3C3; lk = 8'hFF;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        access(1'b0, 12'h100, 32'h0);
        for (int v = 0; v < NV; v++) chk("R1", $sformatf("lock word v%0d", v), rdd[v], 32'hFFFF_0001);
        access(1'b0, 12'h000, 32'h0);
        for (int v = 0; v < NV; v++) chk("R1", $sformatf("slot0 v%0d", v), rdd[v], C0I[v]);

        // full read sweep against reset state (R1, R3, R4, R5)
        for (int a = 0; a < 4096; a += 4) access(1'b0, 12'(a), 32'h0);

        // misaligned accesses (R4)
        access(1'b1, 12'h001, 32'hFFFF_FFFF);
        access(1'b1, 12'h006, 32'hFFFF_FFFF);
        access(1'b1, 12'h102, 32'h0000_0000);
        access(1'b0, 12'h001, 32'h0);
        access(1'b0, 12'h102, 32'h0);
        access(1'b0, 12'hFFD, 32'h0);

        // write every word offset, then read each back (R2, R3, R4, R5, R9)
        for (int a = 0; a < 4096; a += 4) access(1'b1, 12'(a), 32'h9E37_79B9 * 32'(a + 1));
        for (int a = 0; a < 4096; a += 4) access(1'b0, 12'(a), 32'h0);

        // back-to-back write then read in the slot range (R2, R9, R6, R7)
        for (int a = 0; a < 32; a += 4) begin
            access(1'b1, 12'(a), ~(32'h0137_5A5A * 32'(a + 3)));
            access(1'b0, 12'(a), 32'h0);
        end

        // switch input changes (R5)
        sw = 32'hA5A5_0F0F;
        access(1'b0, 12'h00C, 32'h0);

        // mask and lock grid (R8)
        for (int m = 0; m < 256; m += 17) begin
            access(1'b1, 12'h100, {8'(m), 24'hFF_FFFF});
            for (int l = 0; l < 256; l += 15) begin
                lk = 8'(l);
                access(1'b0, 12'h100, 32'h0);
            end
        end
        lk = 8'hFF;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule